// File: doc/BRIEF.md
# Power-Fail Protected Static Memory Controller

This block is a clock-synchronous model of a byte-wide static memory with a supply supervisor built in. The memory is an 8192 x 8 array. Active-low chip-select, write-strobe and output-enable inputs drive it, and the block samples these inputs on each rising clock edge. A write window is open only while both the chip-select and the write strobe are low. The window therefore starts at whichever of the two falls later and ends at whichever rises first. The addressed word is updated when the window closes. Read data is presented one cycle after a read condition is sampled, together with an output-enable flag. While that flag is low the data bus is modelled as high impedance and reads as zero.

The supervisor takes three synchronized one-bit supply indications from an external comparator: above the resume level, above the protect level and above the battery-switch level. It moves between three states: running, held (write-protected) and on battery.

Outside the running state the block ignores every access input, blocks every write and aborts any write window that is open. It also turns the data outputs off. Leaving the held state needs the higher resume level, which gives hysteresis against the protect level. A status output shows when the array is on the backup source. A programmable recovery gap after each write rejects strobes that come too early, and each such rejection sets a sticky error flag.

Top module: `nv_sram_ctrl`

## Requirements
- R1: A word written at an address is returned by a later read of that address. Every one of the 2^ADDR_W addresses holds its own DATA_W-bit value, with no aliasing.
- R2: When chip-select and output-enable are low and the write strobe is high in the running state at an edge, data_oe_o is 1 after that edge, and data_o carries the addressed word. Under any other sampled condition, data_oe_o is 0 after the edge.
- R3: A write window is open while chip-select and the write strobe are both sampled low. Either strobe can open it last, and either can close it first. The array is updated at the first edge at which the window is sampled closed, and not earlier.
- R4: A write uses the address sampled at the edge where its window opened, even if addr_i later changes. It stores the data sampled at the last edge at which the window was open.
- R5: A write strobe falling while outputs are enabled turns data_oe_o off at the next edge.
- R6: supply_state_o encodes 0 = running, 1 = held, 2 = battery. The state goes from running to held when the protect flag is low. From held it returns to running only when the resume flag is high. From any state it goes to battery when the switch flag is low. From battery it goes to held when the switch flag is high. In every one of these transitions the switch flag has priority.
- R7: During reset, supply_state_o is 1 (held), data_oe_o is 0, data_o is 0 and wr_err_o is 0.
- R8: In the held or battery state, no write reaches the array, all access inputs are ignored, data_oe_o is 0 and data_o is 0.
- R9: on_backup_o is 1 exactly while supply_state_o is 2 (battery).
- R10: A write window that is open when the state leaves running is aborted, and the array keeps its previous contents.
- R11: A write start is accepted only if it is sampled at least REC_CYC+1 edges after the edge at which the previous write closed. An earlier start is ignored for as long as its strobes stay active, and it sets wr_err_o. wr_err_o stays at 1 until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | ADDR_W | Word address |
| data_i | input | DATA_W | Write data |
| ce_ni | input | 1 | Chip select, active low |
| we_ni | input | 1 | Write strobe, active low |
| oe_ni | input | 1 | Output enable, active low |
| sup_resume_i | input | 1 | Supply above resume level |
| sup_protect_i | input | 1 | Supply above protect level |
| sup_switch_i | input | 1 | Supply above battery-switch level |
| data_o | output | DATA_W | Read data, zero when outputs are off |
| data_oe_o | output | 1 | Data output drivers enabled |
| supply_state_o | output | 2 | Supervisor state (0 run, 1 held, 2 battery) |
| on_backup_o | output | 1 | Array is on the backup source |
| wr_err_o | output | 1 | Sticky error for a write attempted inside the recovery gap |

## Verification
The assertions check the following on every cycle:
- the output-enable rule, and data_o being zero whenever the outputs are off;
- the output disable that follows a falling write strobe;
- that no array write happens outside the running state;
- the hysteresis hold of the held state and the battery switch;
- that the error flag stays set once raised.

Only the bench's scenarios can show the stored contents. It sweeps every address of a small array with two data patterns and two strobe orderings. It then shows the following by reading the array back:
- writes attempted while held or on battery are lost;
- a window cut by a supply drop is lost;
- the address latched at the start of a window is the one written;
- a strobe inside the recovery gap changes nothing.

// File: rtl/nvs_pkg.sv
package nvs_pkg;
  typedef enum logic [1:0] {
    SUP_RUN  = 2'd0,
    SUP_HOLD = 2'd1,
    SUP_BATT = 2'd2
  } sup_state_e;
endpackage

// File: rtl/nvs_supply_fsm.sv
module nvs_supply_fsm
  import nvs_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       above_resume_i,
  input  logic       above_protect_i,
  input  logic       above_switch_i,
  output sup_state_e state_o
);
  sup_state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      SUP_RUN: begin
        if (!above_switch_i)       state_d = SUP_BATT;
        else if (!above_protect_i) state_d = SUP_HOLD;
      end
      SUP_HOLD: begin
        if (!above_switch_i)      state_d = SUP_BATT;
        else if (above_resume_i)  state_d = SUP_RUN;
      end
      SUP_BATT: begin
        if (above_switch_i) state_d = SUP_HOLD;
      end
      default: state_d = SUP_HOLD;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= SUP_HOLD;
    else         state_q <= state_d;
  end

  assign state_o = state_q;
endmodule

// File: rtl/nvs_access_ctrl.sv
module nvs_access_ctrl #(
  parameter int ADDR_W  = 13,
  parameter int DATA_W  = 8,
  parameter int REC_CYC = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              run_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic              ce_ni,
  input  logic              we_ni,
  input  logic              oe_ni,
  output logic              mem_we_o,
  output logic [ADDR_W-1:0] mem_waddr_o,
  output logic [DATA_W-1:0] mem_wdata_o,
  output logic              rd_en_o,
  output logic              rd_vld_o,
  output logic              wr_err_o
);
  localparam int REC_W = $clog2(REC_CYC + 2);
  localparam logic [REC_W-1:0] REC_LOAD = REC_W'(REC_CYC);

  logic              wr_req, rd_req;
  logic              win_q, rej_q, err_q, vld_q;
  logic [REC_W-1:0]  rec_q;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] data_q;

  assign wr_req = !ce_ni && !we_ni;
  assign rd_req = !ce_ni && !oe_ni && we_ni;

  // commit on the first edge the window is seen closed
  assign mem_we_o    = win_q && !wr_req && run_i;
  assign mem_waddr_o = addr_q;
  assign mem_wdata_o = data_q;
  assign rd_en_o     = rd_req && run_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      win_q  <= 1'b0;
      rej_q  <= 1'b0;
      err_q  <= 1'b0;
      vld_q  <= 1'b0;
      rec_q  <= '0;
      addr_q <= '0;
      data_q <= '0;
    end else begin
      vld_q <= rd_req && run_i;
      if (rec_q != '0) rec_q <= rec_q - 1'b1;
      if (!run_i) begin
        // protection: abort any open window, ignore strobes
        win_q <= 1'b0;
        rej_q <= 1'b0;
      end else if (win_q) begin
        if (wr_req) begin
          data_q <= data_i;
        end else begin
          win_q <= 1'b0;
          rec_q <= REC_LOAD;
        end
      end else if (wr_req) begin
        if (!rej_q) begin
          if (rec_q == '0) begin
            win_q  <= 1'b1;
            addr_q <= addr_i;
            data_q <= data_i;
          end else begin
            rej_q <= 1'b1;
            err_q <= 1'b1;
          end
        end
      end else begin
        rej_q <= 1'b0;
      end
    end
  end

  assign rd_vld_o = vld_q;
  assign wr_err_o = err_q;
endmodule

// File: rtl/nvs_array.sv
module nvs_array #(
  parameter int ADDR_W = 13,
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] waddr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              re_i,
  input  logic [ADDR_W-1:0] raddr_i,
  output logic [DATA_W-1:0] rdata_o
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem_q [DEPTH];
  logic [DATA_W-1:0] rdata_q;

  always_ff @(posedge clk_i) begin
    if (we_i) mem_q[waddr_i] <= wdata_i;
    if (re_i) rdata_q <= mem_q[raddr_i];
  end

  assign rdata_o = rdata_q;
endmodule

// File: rtl/nv_sram_ctrl.sv
module nv_sram_ctrl
  import nvs_pkg::*;
#(
  parameter int ADDR_W  = 13,
  parameter int DATA_W  = 8,
  parameter int REC_CYC = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic              ce_ni,
  input  logic              we_ni,
  input  logic              oe_ni,
  input  logic              sup_resume_i,
  input  logic              sup_protect_i,
  input  logic              sup_switch_i,
  output logic [DATA_W-1:0] data_o,
  output logic              data_oe_o,
  output logic [1:0]        supply_state_o,
  output logic              on_backup_o,
  output logic              wr_err_o
);
  sup_state_e        sup_state;
  logic              run;
  logic              mem_we, rd_en, rd_vld;
  logic [ADDR_W-1:0] mem_waddr;
  logic [DATA_W-1:0] mem_wdata, rdata;

  nvs_supply_fsm u_sup (
    .clk_i           (clk_i),
    .rst_ni          (rst_ni),
    .above_resume_i  (sup_resume_i),
    .above_protect_i (sup_protect_i),
    .above_switch_i  (sup_switch_i),
    .state_o         (sup_state)
  );

  assign run = (sup_state == SUP_RUN);

  nvs_access_ctrl #(
    .ADDR_W  (ADDR_W),
    .DATA_W  (DATA_W),
    .REC_CYC (REC_CYC)
  ) u_ctrl (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .run_i       (run),
    .addr_i      (addr_i),
    .data_i      (data_i),
    .ce_ni       (ce_ni),
    .we_ni       (we_ni),
    .oe_ni       (oe_ni),
    .mem_we_o    (mem_we),
    .mem_waddr_o (mem_waddr),
    .mem_wdata_o (mem_wdata),
    .rd_en_o     (rd_en),
    .rd_vld_o    (rd_vld),
    .wr_err_o    (wr_err_o)
  );

  nvs_array #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W)
  ) u_mem (
    .clk_i   (clk_i),
    .we_i    (mem_we),
    .waddr_i (mem_waddr),
    .wdata_i (mem_wdata),
    .re_i    (rd_en),
    .raddr_i (addr_i),
    .rdata_o (rdata)
  );

  assign data_oe_o      = rd_vld;
  assign data_o         = rd_vld ? rdata : '0;
  assign supply_state_o = sup_state;
  assign on_backup_o    = (sup_state == SUP_BATT);
endmodule

// File: rtl/nvs_checker.sv
module nvs_checker
  import nvs_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              ce_ni,
  input logic              we_ni,
  input logic              oe_ni,
  input logic              sup_resume_i,
  input logic              sup_switch_i,
  input logic [DATA_W-1:0] data_o,
  input logic              data_oe_o,
  input logic [1:0]        supply_state_o,
  input logic              on_backup_o,
  input logic              wr_err_o,
  input logic              mem_we
);
  // R2
  read_enable_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ce_ni && !oe_ni && we_ni && supply_state_o == SUP_RUN) |=> data_oe_o);

  // R8
  bus_off_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !data_oe_o |-> (data_o == '0));

  // R5
  we_fall_off_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (data_oe_o && !we_ni) |=> !data_oe_o);

  // R8
  protect_off_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (supply_state_o != SUP_RUN) |=> !data_oe_o);

  // R10
  no_write_protected_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_we |-> (supply_state_o == SUP_RUN));

  // R6
  hold_hysteresis_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (supply_state_o == SUP_HOLD && !sup_resume_i && sup_switch_i) |=> (supply_state_o == SUP_HOLD));

  // R9
  backup_switch_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sup_switch_i |=> on_backup_o);

  // R11
  err_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_err_o |=> wr_err_o);
endmodule

bind nv_sram_ctrl nvs_checker #(.DATA_W(DATA_W)) u_chk (
  .clk_i          (clk_i),
  .rst_ni         (rst_ni),
  .ce_ni          (ce_ni),
  .we_ni          (we_ni),
  .oe_ni          (oe_ni),
  .sup_resume_i   (sup_resume_i),
  .sup_switch_i   (sup_switch_i),
  .data_o         (data_o),
  .data_oe_o      (data_oe_o),
  .supply_state_o (supply_state_o),
  .on_backup_o    (on_backup_o),
  .wr_err_o       (wr_err_o),
  .mem_we         (mem_we)
);

// File: tb/nv_sram_ctrl_test.sv
module nv_sram_ctrl_test;
  localparam int CLK_PERIOD = 10;
  localparam int AW  = 8;
  localparam int DW  = 8;
  localparam int REC = 2;
  localparam int N   = 1 << AW;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] wdat = '0;
  logic          ce_n = 1'b1, we_n = 1'b1, oe_n = 1'b1;
  logic          s_res = 1'b1, s_pro = 1'b1, s_sw = 1'b1;
  logic [DW-1:0] dout;
  logic          doe, on_bat, err;
  logic [1:0]    sst;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;
  logic [DW-1:0] ref_mem [N];

  always #(CLK_PERIOD/2) clk = ~clk;

  nv_sram_ctrl #(.ADDR_W(AW), .DATA_W(DW), .REC_CYC(REC)) uut (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .data_i(wdat),
    .ce_ni(ce_n), .we_ni(we_n), .oe_ni(oe_n),
    .sup_resume_i(s_res), .sup_protect_i(s_pro), .sup_switch_i(s_sw),
    .data_o(dout), .data_oe_o(doe), .supply_state_o(sst),
    .on_backup_o(on_bat), .wr_err_o(err)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  function automatic logic [DW-1:0] pat(input int a, input int seed);
    return DW'((a * 29 + seed) ^ (a >> 2));
  endfunction

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic idle();
    ce_n = 1'b1; we_n = 1'b1; oe_n = 1'b1;
  endtask

  // write framed by WE inside CE
  task automatic wr_we(input logic [AW-1:0] a, input logic [DW-1:0] d);
    addr = a; wdat = d; ce_n = 1'b0; we_n = 1'b0; oe_n = 1'b1;
    tick();
    idle();
    tick();
    repeat (REC) tick();
  endtask

  // WE falls first, CE falls later and rises first
  task automatic wr_ce(input logic [AW-1:0] a, input logic [DW-1:0] d);
    addr = a; wdat = d; we_n = 1'b0; oe_n = 1'b1;
    tick();
    ce_n = 1'b0;
    tick();
    ce_n = 1'b1;
    tick();
    we_n = 1'b1;
    repeat (REC) tick();
  endtask

  task automatic rd(input logic [AW-1:0] a, input logic [DW-1:0] exp, input string tag);
    addr = a; ce_n = 1'b0; oe_n = 1'b0; we_n = 1'b1;
    tick();
    check({tag, " oe"}, doe, 1);
    check({tag, " data"}, dout, exp);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    tick();
    // R7 reset state
    check("R7 state", sst, 1);
    check("R7 oe", doe, 0);
    check("R7 data", dout, 0);
    check("R7 err", err, 0);
    rst_n = 1'b1;
    tick();
    check("R6 resume to run", sst, 0);

    // R1 R3 sweep, WE framed, then CE framed
    for (int a = 0; a < N; a++) begin
      ref_mem[a] = pat(a, 5);
      wr_we(AW'(a), ref_mem[a]);
    end
    for (int a = 0; a < N; a++) rd(AW'(a), ref_mem[a], "R1 sweep A");
    idle(); tick();
    for (int a = 0; a < N; a++) begin
      ref_mem[a] = pat(a, 113);
      wr_ce(AW'(a), ref_mem[a]);
    end
    for (int a = N - 1; a >= 0; a--) rd(AW'(a), ref_mem[a], "R3 sweep CE framed");
    idle(); tick();
    check("R11 no err after spaced writes", err, 0);

    // R2 non-read conditions
    addr = 8'h10; ce_n = 1'b1; oe_n = 1'b0; we_n = 1'b1; tick();
    check("R2 ce high oe", doe, 0);
    check("R2 ce high data", dout, 0);
    ce_n = 1'b0; oe_n = 1'b1; tick();
    check("R2 oe high oe", doe, 0);
    check("R2 oe high data", dout, 0);
    idle(); tick();

    // R5 WE falls during a read (rewrites same value)
    rd(8'h21, ref_mem[8'h21], "R5 pre");
    wdat = ref_mem[8'h21]; we_n = 1'b0; tick();
    check("R5 oe off after WE fall", doe, 0);
    check("R5 data off", dout, 0);
    idle(); tick(); repeat (REC) tick();

    // R3 commit not before close
    addr = 8'h30; wdat = 8'hA5; ce_n = 1'b0; we_n = 1'b0; tick(); tick();
    oe_n = 1'b0;
    check("R2 no output during write", doe, 0);
    oe_n = 1'b1;
    idle(); tick(); repeat (REC) tick();
    ref_mem[8'h30] = 8'hA5;
    rd(8'h30, 8'hA5, "R3 held window commit");
    idle(); tick();

    // R4 address latched at start, last data used
    addr = 8'h40; wdat = 8'h11; ce_n = 1'b0; we_n = 1'b0; tick();
    addr = 8'h41; wdat = 8'h77; tick();
    idle(); tick(); repeat (REC) tick();
    ref_mem[8'h40] = 8'h77;
    rd(8'h40, 8'h77, "R4 start address");
    rd(8'h41, ref_mem[8'h41], "R4 other address untouched");
    idle(); tick();

    // R6 R8 held state, hysteresis
    s_pro = 1'b0; s_res = 1'b0; tick();
    check("R6 run to held", sst, 1);
    check("R9 not backup", on_bat, 0);
    wr_we(8'h50, 8'hEE);
    addr = 8'h50; ce_n = 1'b0; oe_n = 1'b0; tick();
    check("R8 no read when held", doe, 0);
    idle();
    s_pro = 1'b1; tick();
    check("R6 hysteresis stays held", sst, 1);
    s_sw = 1'b0; tick();
    check("R6 held to battery", sst, 2);
    check("R9 backup on", on_bat, 1);
    wr_ce(8'h51, 8'hDD);
    s_sw = 1'b1; tick();
    check("R6 battery to held", sst, 1);
    check("R9 backup off", on_bat, 0);
    s_res = 1'b1; tick();
    check("R6 held to run", sst, 0);
    rd(8'h50, ref_mem[8'h50], "R8 held write blocked");
    rd(8'h51, ref_mem[8'h51], "R8 battery write blocked");
    idle(); tick();

    // R6 switch priority from run
    s_sw = 1'b0; s_pro = 1'b0; s_res = 1'b0; tick();
    check("R6 run to battery", sst, 2);
    s_sw = 1'b1; s_pro = 1'b1; s_res = 1'b1; tick(); tick();
    check("R6 back to run", sst, 0);

    // R10 abort on supply drop
    addr = 8'h60; wdat = 8'h5A; ce_n = 1'b0; we_n = 1'b0; tick();
    s_pro = 1'b0; s_res = 1'b0; tick(); tick();
    idle(); tick();
    s_pro = 1'b1; s_res = 1'b1; tick(); tick();
    check("R10 run again", sst, 0);
    rd(8'h60, ref_mem[8'h60], "R10 aborted write");
    idle(); tick();
    check("R10 no error", err, 0);

    // R11 recovery gap
    addr = 8'h70; wdat = 8'h12; ce_n = 1'b0; we_n = 1'b0; tick();
    idle(); tick();
    ref_mem[8'h70] = 8'h12;
    addr = 8'h71; wdat = 8'h34; ce_n = 1'b0; we_n = 1'b0; tick();
    check("R11 err set", err, 1);
    tick(); tick(); tick();
    idle(); tick(); repeat (REC) tick();
    rd(8'h71, ref_mem[8'h71], "R11 early write ignored");
    rd(8'h70, 8'h12, "R11 first write kept");
    idle(); tick();
    wr_we(8'h72, 8'h9C);
    ref_mem[8'h72] = 8'h9C;
    rd(8'h72, 8'h9C, "R11 later write accepted");
    idle(); tick();
    check("R11 err sticky", err, 1);

    // R7 reset again clears error
    rst_n = 1'b0; tick();
    check("R7 err cleared", err, 0);
    check("R7 held in reset", sst, 1);
    rst_n = 1'b1; tick();
    rd(8'h72, 8'h9C, "R1 contents kept across reset");
    idle(); tick();

    finish_run();
  end
endmodule